// File: doc/BRIEF.md
# Scatter-Gather Audio Playback DMA Channel

This block is one playback channel of an audio controller. Software builds a table of 8-byte descriptors in memory, writes the table's start address into the channel and starts it. The channel then walks the table. It fetches each descriptor, reads the sample buffer it points to one 32-bit word at a time through a simple request/acknowledge memory read port, and hands the bytes in address order to an audio sink over a valid/ready byte stream.

Each descriptor can carry three markers. A flag marker and a stop marker pause the channel when their buffer is used up. An end-of-list marker sends the walk back to the table start, and then either pauses the channel or stops it. Software resumes a paused channel by clearing the matching status bit, or through the control register. A level interrupt reports end-of-list and flag events when each is enabled. The sample-format bits of the type register are presented to the sink side, with a one-cycle pulse whenever either of them changes.

Top module: `sgd_play_chan`

## Requirements
- R1: A descriptor is two 32-bit words: first the buffer address, then a control word in which bit 31 marks end of list, bit 30 marks flag, bit 29 marks stop and bits 23:0 give the byte count. After each descriptor fetch the descriptor pointer (read at offset 5) advances by 8.
- R2: Buffer bytes leave on the sink in ascending address order. The byte at address a is bits 8*(a mod 4)+7 down to 8*(a mod 4) of the little-endian memory word at a with its two low bits cleared. The remaining count (read at offset 4) drops by one for each byte the sink accepts.
- R3: A descriptor with a zero byte count produces no sink bytes and no buffer read. Its markers take effect at once.
- R4: When a flag descriptor is used up, status bit 0 (flag) and bit 6 (paused) are set, and irq rises if type bit 0 is set.
- R5: When a stop descriptor is used up, status bit 2 (stop) and bit 6 (paused) are set.
- R6: When an end-of-list descriptor is used up, status bit 1 is set and the descriptor pointer returns to the base. With type bit 7 set, paused is set. Otherwise active (bit 7) is cleared. irq is high while status bit 1 and type bit 1 are both set.
- R7: Writing status (offset 0) with bit 0 or bit 1 set clears that bit together with paused, and the interrupt it caused drops. Writing bit 2 clears paused only. Zero bits in the write have no effect.
- R8: Control (offset 1, reads 0) is applied in this order. Bit 7 makes the status exactly active. Bit 6 clears active and paused. Bit 3 clears active and sets paused. A write with bit 3 clear while paused sets active and clears paused.
- R9: No memory request starts and the sink sees no valid byte unless the status is active and not paused. A started request is held with a stable address until it is acknowledged.
- R10: Writing the base (offset 3) stores the value with bit 0 forced to zero and reloads the descriptor pointer with it.
- R11: fmt_stereo follows type bit 4 and fmt_wide follows type bit 5. fmt_reload is high for one cycle after a type write (offset 2) that changes either bit, and stays low otherwise.
- R12: Status bit 3 reads 1 whenever active or paused is set. Status bits 5:4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | AW | Byte address of the requested word (low two bits zero for buffer reads) |
| mem_ack | input | 1 | Memory acknowledge, mem_rdata valid |
| mem_rdata | input | 32 | Memory read word, little-endian |
| snk_valid | output | 1 | Sample byte valid |
| snk_data | output | 8 | Sample byte |
| snk_ready | input | 1 | Sink accepts the byte |
| irq | output | 1 | Level interrupt |
| fmt_stereo | output | 1 | Two-channel format selected |
| fmt_wide | output | 1 | 16-bit samples selected |
| fmt_reload | output | 1 | One-cycle pulse: format bits changed |

## Verification
The bench builds the channel with a 16-bit address and the full 24-bit count, over a 1 KiB word memory. Every buffer start offset within a word is swept against byte counts zero to five, with a sink that stalls one cycle in three. This covers each byte lane, a run that crosses a word boundary and one that ends mid-word, and the zero-length case. A table that mixes flag, stop and looping end-of-list descriptors, together with a pause placed while a byte waits at the sink, drives the status and control precedence rules and the interrupt enables through their corner cases.

// File: rtl/sgd_pkg.sv
// Shared encodings of the playback channel: register offsets, bit positions,
// walker states and the descriptor marker bundle.
package sgd_pkg;
    localparam int RA_W = 3;
    localparam logic [RA_W-1:0] RA_STAT = 3'd0;
    localparam logic [RA_W-1:0] RA_CTRL = 3'd1;
    localparam logic [RA_W-1:0] RA_TYPE = 3'd2;
    localparam logic [RA_W-1:0] RA_BASE = 3'd3;
    localparam logic [RA_W-1:0] RA_LEFT = 3'd4;
    localparam logic [RA_W-1:0] RA_PTR  = 3'd5;

    localparam int SB_ACT = 7, SB_PAU = 6, SB_TRG = 3, SB_STP = 2, SB_EOL = 1, SB_FLG = 0;
    localparam int CB_START = 7, CB_TERM = 6, CB_PAUSE = 3;
    localparam int TB_FLGIE = 0, TB_EOLIE = 1, TB_STEREO = 4, TB_WIDE = 5, TB_LOOP = 7;
    localparam int DB_EOL = 31, DB_FLG = 30, DB_STP = 29;

    typedef enum logic [2:0] {W_DA, W_DC, W_RD, W_OUT, W_END} walk_t;

    typedef struct packed {
        logic eol;
        logic flg;
        logic stp;
    } dmark_t;

    typedef struct packed {
        logic act;
        logic pau;
        logic stp;
        logic eol;
        logic flg;
    } chst_t;
endpackage

// File: rtl/sgd_regs.sv
// Channel registers: status with write-one-to-clear, control actions, type and
// base. Assumes one register write per cycle. Walker events are applied after
// software writes in the same cycle, so a completion is never lost.
module sgd_regs
    import sgd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [31:0]     reg_wdata,
    input  logic            ev_end,
    input  dmark_t          ev_mark,
    output logic [7:0]      stat_byte,
    output logic [7:0]      typ,
    output logic [AW-1:0]   base,
    output logic            base_load,
    output logic [AW-1:0]   base_wr,
    output logic            run,
    output logic            irq,
    output logic            fmt_stereo,
    output logic            fmt_wide,
    output logic            fmt_reload
);
    chst_t st, st_n;

    logic wr_stat, wr_ctrl, wr_type;
    assign wr_stat   = reg_we && (reg_addr == RA_STAT);
    assign wr_ctrl   = reg_we && (reg_addr == RA_CTRL);
    assign wr_type   = reg_we && (reg_addr == RA_TYPE);
    assign base_load = reg_we && (reg_addr == RA_BASE);
    assign base_wr   = reg_wdata[AW-1:0] & ~AW'(1);

    // Next status: software clears, then control actions, then walker events.
    always_comb begin
        st_n = st;
        if (wr_stat) begin
            if (reg_wdata[SB_STP]) st_n.pau = 1'b0;
            if (reg_wdata[SB_EOL]) begin st_n.eol = 1'b0; st_n.pau = 1'b0; end
            if (reg_wdata[SB_FLG]) begin st_n.flg = 1'b0; st_n.pau = 1'b0; end
        end
        if (wr_ctrl) begin
            if (reg_wdata[CB_START]) st_n = '{act: 1'b1, default: 1'b0};
            if (reg_wdata[CB_TERM]) begin st_n.act = 1'b0; st_n.pau = 1'b0; end
            if (reg_wdata[CB_PAUSE]) begin
                st_n.act = 1'b0;
                st_n.pau = 1'b1;
            end else if (st_n.pau) begin
                st_n.act = 1'b1;
                st_n.pau = 1'b0;
            end
        end
        if (ev_end) begin
            if (ev_mark.eol) begin
                st_n.eol = 1'b1;
                if (typ[TB_LOOP]) st_n.pau = 1'b1;
                else              st_n.act = 1'b0;
            end
            if (ev_mark.flg) begin st_n.flg = 1'b1; st_n.pau = 1'b1; end
            if (ev_mark.stp) begin st_n.stp = 1'b1; st_n.pau = 1'b1; end
        end
    end

    // Register state: status, type, base and the format-change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= '0;
            typ        <= '0;
            base       <= '0;
            fmt_reload <= 1'b0;
        end else begin
            st         <= st_n;
            fmt_reload <= wr_type && (reg_wdata[TB_WIDE:TB_STEREO] != typ[TB_WIDE:TB_STEREO]);
            if (wr_type)   typ  <= reg_wdata[7:0];
            if (base_load) base <= base_wr;
        end
    end

    // Derived outputs: status byte image, run gate, interrupt level, format.
    always_comb begin
        stat_byte         = '0;
        stat_byte[SB_ACT] = st.act;
        stat_byte[SB_PAU] = st.pau;
        stat_byte[SB_TRG] = st.act | st.pau;
        stat_byte[SB_STP] = st.stp;
        stat_byte[SB_EOL] = st.eol;
        stat_byte[SB_FLG] = st.flg;
    end
    assign run        = st.act & ~st.pau;
    assign irq        = (st.eol & typ[TB_EOLIE]) | (st.flg & typ[TB_FLGIE]);
    assign fmt_stereo = typ[TB_STEREO];
    assign fmt_wide   = typ[TB_WIDE];

    // R4: a finished flag descriptor leaves flag and paused set.
    p_flag_pause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_end && ev_mark.flg) |=> (st.flg && st.pau));
    // R8: a plain start leaves exactly active.
    p_start_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && reg_wdata[CB_START] && !reg_wdata[CB_TERM] && !reg_wdata[CB_PAUSE] && !ev_end)
        |=> (st.act && !st.pau && !st.stp && !st.eol && !st.flg));
    // R7: writing one to the flag bit clears it.
    p_w1c_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[SB_FLG] && !ev_end) |=> !st.flg);
endmodule

// File: rtl/sgd_walk.sv
// Descriptor walker and byte streamer. Fetches the address word, then the
// control word, then buffer words one at a time, and presents their bytes to
// the sink. Assumes the memory acknowledges each held request exactly once.
// New requests start only while run is high; an issued one is always finished.
module sgd_walk
    import sgd_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [AW-1:0] base,
    input  logic          base_load,
    input  logic [AW-1:0] base_wr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          snk_valid,
    output logic [7:0]    snk_data,
    input  logic          snk_ready,
    output logic          ev_end,
    output dmark_t        ev_mark,
    output logic [LW-1:0] left,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] DESC_BYTES = AW'(8);
    localparam logic [AW-1:0] CTL_OFFS   = AW'(4);

    walk_t         state;
    logic [AW-1:0] curr;
    logic [AW-1:0] baddr;
    logic [LW-1:0] len;
    logic [31:0]   word;
    dmark_t        mark;
    logic          unused_rdata;

    assign unused_rdata = ^mem_rdata;

    // Walk sequence: request, capture, stream, then report completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= W_DA;
            mem_req  <= 1'b0;
            mem_addr <= '0;
            curr     <= '0;
            baddr    <= '0;
            len      <= '0;
            word     <= '0;
            mark     <= '0;
        end else begin
            case (state)
                W_DA, W_DC, W_RD: begin
                    if (!mem_req) begin
                        if (run) begin
                            mem_req  <= 1'b1;
                            mem_addr <= (state == W_DA) ? curr :
                                        (state == W_DC) ? curr + CTL_OFFS :
                                        {baddr[AW-1:2], 2'b00};
                        end
                    end else if (mem_ack) begin
                        mem_req <= 1'b0;
                        case (state)
                            W_DA: begin
                                baddr <= mem_rdata[AW-1:0];
                                state <= W_DC;
                            end
                            W_DC: begin
                                len   <= mem_rdata[LW-1:0];
                                mark  <= '{eol: mem_rdata[DB_EOL], flg: mem_rdata[DB_FLG],
                                           stp: mem_rdata[DB_STP]};
                                curr  <= curr + DESC_BYTES;
                                state <= (mem_rdata[LW-1:0] == '0) ? W_END : W_RD;
                            end
                            default: begin
                                word  <= mem_rdata;
                                state <= W_OUT;
                            end
                        endcase
                    end
                end
                W_OUT: begin
                    if (run && snk_ready) begin
                        baddr <= baddr + AW'(1);
                        len   <= len - LW'(1);
                        if (len == LW'(1))            state <= W_END;
                        else if (baddr[1:0] == 2'd3)  state <= W_RD;
                    end
                end
                W_END: begin
                    if (mark.eol) curr <= base;
                    state <= W_DA;
                end
                default: state <= W_DA;
            endcase
            if (base_load) curr <= base_wr;
        end
    end

    assign snk_valid = (state == W_OUT) && run;
    assign snk_data  = word[{baddr[1:0], 3'b000} +: 8];
    assign ev_end    = (state == W_END);
    assign ev_mark   = mark;
    assign left      = len;
    assign ptr       = curr;

    // R9: a request is held, address unchanged, until acknowledged.
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    // R9: a request only starts after a cycle in which the channel ran.
    p_fetch_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(run));
    // R2: each accepted byte lowers the remaining count by one.
    p_len_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_valid && snk_ready) |=> (left == $past(left) - LW'(1)));
    // R1: a control-word fetch advances the pointer by one descriptor.
    p_ptr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == W_DC && mem_req && mem_ack && !base_load) |=> (ptr == $past(ptr) + DESC_BYTES));
endmodule

// File: rtl/sgd_play_chan.sv
// Top of the playback channel: joins the register block and the walker and
// drives the combinational register read-back.
module sgd_play_chan
    import sgd_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_ack,
    input  logic [31:0]     mem_rdata,
    output logic            snk_valid,
    output logic [7:0]      snk_data,
    input  logic            snk_ready,
    output logic            irq,
    output logic            fmt_stereo,
    output logic            fmt_wide,
    output logic            fmt_reload
);
    logic [7:0]    stat_byte, typ;
    logic [AW-1:0] base, base_wr, ptr;
    logic          base_load, run, ev_end;
    dmark_t        ev_mark;
    logic [LW-1:0] left;

    sgd_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ev_end(ev_end), .ev_mark(ev_mark),
        .stat_byte(stat_byte), .typ(typ), .base(base), .base_load(base_load),
        .base_wr(base_wr), .run(run), .irq(irq), .fmt_stereo(fmt_stereo),
        .fmt_wide(fmt_wide), .fmt_reload(fmt_reload)
    );

    sgd_walk #(.AW(AW), .LW(LW)) u_walk (
        .clk(clk), .rst_n(rst_n), .run(run), .base(base), .base_load(base_load),
        .base_wr(base_wr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .snk_valid(snk_valid),
        .snk_data(snk_data), .snk_ready(snk_ready), .ev_end(ev_end),
        .ev_mark(ev_mark), .left(left), .ptr(ptr)
    );

    // Register read-back selected by offset; control and unused offsets read 0.
    always_comb begin
        case (reg_addr)
            RA_STAT: reg_rdata = 32'(stat_byte);
            RA_TYPE: reg_rdata = 32'(typ);
            RA_BASE: reg_rdata = 32'(base);
            RA_LEFT: reg_rdata = 32'(left);
            RA_PTR:  reg_rdata = 32'(ptr);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: tb/test_sgd_play_chan.sv
`timescale 1ns/1ps
module test_sgd_play_chan;
    localparam int AW = 16;
    localparam int LW = 24;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_ack = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          snk_valid;
    logic [7:0]    snk_data;
    logic          snk_ready = 1'b0;
    logic          irq, fmt_stereo, fmt_wide, fmt_reload;

    sgd_play_chan #(.AW(AW), .LW(LW)) i_sgd_play_chan (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .snk_valid(snk_valid), .snk_data(snk_data), .snk_ready(snk_ready),
        .irq(irq), .fmt_stereo(fmt_stereo), .fmt_wide(fmt_wide),
        .fmt_reload(fmt_reload)
    );

    int nchk = 0, nfail = 0;
    logic [31:0] mem [256];
    logic [7:0]  cap [512];
    int cap_n = 0, rises = 0, reloads = 0, tick = 0, rdy_mode = 1;
    logic req_d = 1'b0;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    // Memory model: acknowledges a held request one cycle later.
    always @(posedge clk) begin
        mem_ack   <= mem_req && !mem_ack;
        mem_rdata <= mem[mem_addr[9:2]];
    end

    // Monitors: captured bytes, request starts, format pulses.
    always @(posedge clk) begin
        if (snk_valid && snk_ready) begin
            cap[cap_n] <= snk_data;
            cap_n <= cap_n + 1;
        end
        req_d <= mem_req;
        if (mem_req && !req_d) rises <= rises + 1;
        if (fmt_reload) reloads <= reloads + 1;
    end

    // Sink ready pattern: 0 stalls one cycle in three, 1 always, 2 never.
    always @(negedge clk) begin
        tick <= tick + 1;
        snk_ready <= (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : ((tick % 3) != 2);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_stat(input string tag, input logic [31:0] mask, input logic [31:0] val);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(3'd0, v);
            if ((v & mask) == val) return;
            @(negedge clk);
        end
        chk({tag, " wait status"}, v & mask, val);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setd(input int a, input logic [31:0] badr, input logic [31:0] ctl);
        mem[a >> 2]       = badr;
        mem[(a >> 2) + 1] = ctl;
    endtask

    task automatic check_bytes(input string tag, input int start, input int badr, input int n);
        chk({tag, " byte count"}, cap_n - start, n);
        for (int i = 0; i < n; i++)
            chk({tag, " byte"}, {24'h0, cap[start + i]}, {24'h0, pat(badr + i)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got 0x0 expected 0x1");
        $display("[TB] %0d tests run, %0d failed", nchk + 1, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int s0, r0;
        for (int w = 0; w < 256; w++)
            mem[w] = {pat(4*w + 3), pat(4*w + 2), pat(4*w + 1), pat(4*w)};
        idle(4);
        rst_n = 1'b1;
        idle(10);

        // Reset state (R9, R12)
        rd(3'd0, v); chk("reset status R12", v, 32'h0);
        rd(3'd2, v); chk("reset type R11", v, 32'h0);
        chk("reset irq R6", {31'h0, irq}, 32'h0);
        chk("reset no request R9", rises, 0);
        chk("reset no valid R9", {31'h0, snk_valid}, 32'h0);

        // Format bits and reload pulse (R11)
        r0 = reloads; wr(3'd2, 32'h10); idle(2);
        chk("R11 stereo pulse", reloads - r0, 1);
        chk("R11 stereo bit", {31'h0, fmt_stereo}, 32'h1);
        r0 = reloads; wr(3'd2, 32'h11); idle(2);
        chk("R11 no pulse on other bits", reloads - r0, 0);
        r0 = reloads; wr(3'd2, 32'h30); idle(2);
        chk("R11 wide pulse", reloads - r0, 1);
        chk("R11 wide bit", {31'h0, fmt_wide}, 32'h1);
        r0 = reloads; wr(3'd2, 32'h00); idle(2);
        chk("R11 clear pulse", reloads - r0, 1);

        // Sweep: offsets 0..3 by lengths 0..5, end-of-list without loop (R1, R2, R3, R6)
        rdy_mode = 0;
        wr(3'd3, 32'h1C0);
        for (int o = 0; o < 4; o++) begin
            for (int n = 0; n < 6; n++) begin
                setd(32'h1C0, 32'h280 + o, 32'h8000_0000 | n);
                s0 = cap_n; r0 = rises;
                wr(3'd1, 32'h80);
                wait_stat("R6 sweep", 32'h80, 32'h0);
                rd(3'd0, v); chk("R6 eol stops, R12 trig clear", v, 32'h02);
                check_bytes("R2 sweep", s0, 32'h280 + o, n);
                rd(3'd4, v); chk("R2 remaining zero", v, 32'h0);
                rd(3'd5, v); chk("R6 pointer back at base", v, 32'h1C0);
                chk("R6 irq disabled", {31'h0, irq}, 32'h0);
                if (n == 0) chk("R3 zero length no buffer read", rises - r0, 2);
            end
        end

        // Flag, stop and looping end-of-list table (R1, R3, R4, R5, R6, R7, R8)
        rdy_mode = 1;
        wr(3'd2, 32'h83);
        wr(3'd3, 32'h100);
        setd(32'h100, 32'h201, 32'h4000_0005);
        setd(32'h108, 32'h210, 32'h2000_0000);
        setd(32'h110, 32'h302, 32'h8000_0007);
        s0 = cap_n;
        wr(3'd1, 32'h80);
        wait_stat("R4 flag", 32'h40, 32'h40);
        rd(3'd0, v); chk("R4 flag pause status", v, 32'hC9);
        chk("R4 flag irq", {31'h0, irq}, 32'h1);
        check_bytes("R2 flag buffer", s0, 32'h201, 5);
        rd(3'd4, v); chk("R2 remaining after flag", v, 32'h0);
        rd(3'd5, v); chk("R1 pointer step", v, 32'h108);
        wr(3'd0, 32'h01);
        rd(3'd0, v); chk("R7 flag w1c", v, 32'h88);
        chk("R7 irq drops", {31'h0, irq}, 32'h0);
        s0 = cap_n;
        wait_stat("R5 stop", 32'h40, 32'h40);
        rd(3'd0, v); chk("R5 stop pause status", v, 32'hCC);
        chk("R3 zero length no bytes", cap_n - s0, 0);
        rd(3'd5, v); chk("R1 pointer second step", v, 32'h110);
        wr(3'd0, 32'h04);
        rd(3'd0, v); chk("R7 stop w1c clears paused only", v, 32'h8C);
        wait_stat("R6 loop", 32'h40, 32'h40);
        rd(3'd0, v); chk("R6 loop pause status", v, 32'hCE);
        chk("R6 eol irq", {31'h0, irq}, 32'h1);
        check_bytes("R2 eol buffer", s0, 32'h302, 7);
        rd(3'd5, v); chk("R6 pointer to base", v, 32'h100);
        wr(3'd1, 32'h08);
        rd(3'd0, v); chk("R8 pause control", v, 32'h4E);
        r0 = rises; idle(20);
        chk("R9 no fetch while paused", rises - r0, 0);
        wr(3'd1, 32'h40);
        rd(3'd0, v); chk("R8 terminate", v, 32'h06);
        chk("R6 irq held by eol", {31'h0, irq}, 32'h1);
        r0 = rises; idle(20);
        chk("R9 no fetch after terminate", rises - r0, 0);
        wr(3'd1, 32'h80);
        rd(3'd0, v); chk("R8 start gives active only", v, 32'h88);
        chk("R8 start drops irq", {31'h0, irq}, 32'h0);
        s0 = cap_n;
        wait_stat("R6 restart", 32'h40, 32'h40);
        rd(3'd0, v); chk("R6 restart from base flag", v, 32'hC9);
        check_bytes("R2 restart buffer", s0, 32'h201, 5);

        // Base reload, pause while a byte waits, control resume (R7, R8, R9, R10)
        wr(3'd2, 32'h00);
        wr(3'd3, 32'h181);
        rd(3'd3, v); chk("R10 base bit0 forced", v, 32'h180);
        rd(3'd5, v); chk("R10 pointer reloaded", v, 32'h180);
        setd(32'h180, 32'h340, 32'h8000_000C);
        rdy_mode = 2;
        idle(2);
        wr(3'd0, 32'h01);
        for (int i = 0; i < 200 && !snk_valid; i++) @(negedge clk);
        chk("R7 w1c flag resumes walk", {31'h0, snk_valid}, 32'h1);
        s0 = cap_n;
        wr(3'd1, 32'h08);
        rd(3'd0, v); chk("R8 pause mid-buffer", v, 32'h48);
        rdy_mode = 1; r0 = rises;
        idle(20);
        chk("R9 no bytes while paused", cap_n - s0, 0);
        chk("R9 valid low while paused", {31'h0, snk_valid}, 32'h0);
        chk("R9 no request while paused", rises - r0, 0);
        rd(3'd4, v); chk("R2 remaining held", v, 32'd12);
        wr(3'd1, 32'h00);
        rd(3'd0, v); chk("R8 resume by clear pause", v, 32'h88);
        wait_stat("R6 no loop", 32'h80, 32'h0);
        rd(3'd0, v); chk("R6 eol without loop", v, 32'h02);
        chk("R6 eol irq disabled", {31'h0, irq}, 32'h0);
        check_bytes("R2 resumed buffer", s0, 32'h340, 12);
        rd(3'd5, v); chk("R6 pointer to new base", v, 32'h180);

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule